// File: doc/BRIEF.md
# Banked Register-Mapped GPIO Controller

This block gives software control over up to 96 general-purpose pins (76 by default) through a small synchronous register bus. Pins are grouped into banks of 32. Each bank has three 32-bit registers. The use-select register marks which pins serve as GPIO. The direction register chooses input or output per pin. The level register holds the output latches and returns pin state when read. The three registers of a bank sit at irregular byte offsets, not at a fixed stride.

Some pins are wired as input-only or output-only. Their direction bits keep the fixed value whatever is written, so software learns of a rejected direction change by reading the register back. A masked set of use-select bits always reads zero. A separate configuration word carries a single enable bit. Until that bit is set, the block decodes no bus access and drives no pin. Pin inputs are resynchronized by two flops before software can see them. Reads are combinational on the address, and writes take effect at the clock edge where `reg_wr` is high.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n belongs to bank n/32 at bit n%32. The byte offsets are fixed as follows. Use-select: bank0 0x00, bank1 0x30, bank2 0x40. Direction: bank0 0x04, bank1 0x34, bank2 0x44. Level: bank0 0x0C, bank1 0x38, bank2 0x48. Decode uses `reg_addr[7:2]`.
- R2: A direction bit of 1 makes the pin an input and 0 makes it an output. While the block is enabled, `pin_oe[n]` equals the inverse of pin n's effective direction bit.
- R3: The direction bit of an input-only pin always reads 1 and that pin is never driven. The direction bit of an output-only pin always reads 0 and that pin is always driven while the block is enabled. Writes never change either kind of bit.
- R4: Use-select bits can be written and read back, except the bits in the USE_ZERO mask, which always read 0.
- R5: A level bit reads the synchronized pin input when the pin is an input and the output latch when it is an output. A level write updates the latches of all pins, including input pins, and `pin_out` shows the latches.
- R6: A change on `pin_in` is not visible in a level read after one rising edge. It is visible after the second rising edge.
- R7: The decoded window is 128 bytes when NPINS > 64 and 64 bytes otherwise. Addresses at or beyond the window read 0. Offsets inside the window that map to no register read 0. Bits for pins at or above NPINS read 0.
- R8: Bit 4 of the configuration word (value 0x10) is the enable, and `cfg_rdata` returns only that bit. While the enable is clear, register reads return 0, register writes are ignored and `pin_oe` is all 0.
- R9: After reset the block is disabled. Every pin that is not output-only is an input. All latches and use-select bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data; bit 4 is the enable |
| cfg_rdata | output | 32 | Configuration read-back (bit 4 only) |
| reg_addr | input | AW | Byte address into the register window |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on the address |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Output latch per pin |
| pin_oe | output | NPINS | Output enable per pin |

## Verification
The bench targets several faults. A design that stored direction writes to fixed-direction pins would read back the written value and drive an input-only pin. A design that left out the use-select mask would report pins 16, 17, 20 and 48 as usable. A design with a one-flop synchronizer would show a new input one edge early. Reads at unmapped offsets (0x08, 0x4C), beyond the window (0x80, 0xFC) and from the unused top bits of bank 2 must return zero, which catches decoders that alias or over-decode. Writes made while disabled must leave no trace once the block is enabled. Random traffic over all offsets, pin changes and enable toggles is compared against a bench model after every step.

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl #(
  parameter int NPINS = 76,
  parameter int AW = 8,
  parameter logic [95:0] IN_ONLY  = (96'd1 << 5) | (96'd1 << 40) | (96'd1 << 70),
  parameter logic [95:0] OUT_ONLY = (96'd1 << 6) | (96'd1 << 33) | (96'd1 << 71),
  parameter logic [95:0] USE_ZERO = (96'd1 << 16) | (96'd1 << 17) | (96'd1 << 20) | (96'd1 << 48)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int NB  = (NPINS + 31) / 32;
  localparam int WIN = (NPINS > 64) ? 128 : 64;
  localparam logic [95:0] VALID = (96'd1 << NPINS) - 96'd1;
  localparam logic [7:0] USE_OFS [3] = '{8'h00, 8'h30, 8'h40};
  localparam logic [7:0] DIR_OFS [3] = '{8'h04, 8'h34, 8'h44};
  localparam logic [7:0] LVL_OFS [3] = '{8'h0C, 8'h38, 8'h48};

  logic        en_q;
  logic [95:0] use_q, dir_q, lvl_q, s1_q, s2_q;
  logic [95:0] dir_eff, use_rd, dir_rd, lvl_rd;
  logic        acc;
  logic [31:0] word_addr;

  assign word_addr = 32'({reg_addr[AW-1:2], 2'b00});
  assign acc       = en_q && (32'(reg_addr) < WIN);
  assign dir_eff   = (dir_q | IN_ONLY) & ~OUT_ONLY;
  assign use_rd    = use_q & ~USE_ZERO & VALID;
  assign dir_rd    = dir_eff & VALID;
  assign lvl_rd    = ((dir_eff & s2_q) | (~dir_eff & lvl_q)) & VALID;
  assign cfg_rdata = {27'd0, en_q, 4'd0};
  assign pin_out   = lvl_q[NPINS-1:0];
  assign pin_oe    = en_q ? ~dir_eff[NPINS-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    if (acc)
      for (int b = 0; b < NB; b++) begin
        if (word_addr == 32'(USE_OFS[b])) reg_rdata = use_rd[b*32 +: 32];
        if (word_addr == 32'(DIR_OFS[b])) reg_rdata = dir_rd[b*32 +: 32];
        if (word_addr == 32'(LVL_OFS[b])) reg_rdata = lvl_rd[b*32 +: 32];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      use_q <= '0;
      dir_q <= '1;
      lvl_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else begin
      s1_q <= 96'(pin_in);
      s2_q <= s1_q;
      if (cfg_wr) en_q <= cfg_wdata[4];
      if (reg_wr && acc)
        for (int b = 0; b < NB; b++) begin
          if (word_addr == 32'(USE_OFS[b])) use_q[b*32 +: 32] <= reg_wdata;
          if (word_addr == 32'(DIR_OFS[b])) dir_q[b*32 +: 32] <= reg_wdata;
          if (word_addr == 32'(LVL_OFS[b])) lvl_q[b*32 +: 32] <= reg_wdata;
        end
    end
  end

  logic [95:0] oe_w, out_w;
  assign oe_w  = 96'(pin_oe);
  assign out_w = 96'(pin_out);

  p_oe_off_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> oe_w == '0);
  p_rd_zero_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> reg_rdata == '0);
  p_in_only_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_w & IN_ONLY) == '0);
  p_out_only_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (oe_w & OUT_ONLY & VALID) == (OUT_ONLY & VALID));
  p_beyond_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(reg_addr) >= WIN) |-> reg_rdata == '0);
  p_latch_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && acc && word_addr == 32'(LVL_OFS[0])) |=>
      out_w[31:0] == ($past(reg_wdata) & VALID[31:0]));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  localparam int NPINS = 76;
  localparam int WIN = 128;
  localparam logic [95:0] VALID = (96'd1 << NPINS) - 96'd1;
  localparam logic [95:0] IN_ONLY  = (96'd1 << 5) | (96'd1 << 40) | (96'd1 << 70);
  localparam logic [95:0] OUT_ONLY = (96'd1 << 6) | (96'd1 << 33) | (96'd1 << 71);
  localparam logic [95:0] USE_ZERO = (96'd1 << 16) | (96'd1 << 17) | (96'd1 << 20) | (96'd1 << 48);
  localparam logic [7:0] A_USE [3] = '{8'h00, 8'h30, 8'h40};
  localparam logic [7:0] A_DIR [3] = '{8'h04, 8'h34, 8'h44};
  localparam logic [7:0] A_LVL [3] = '{8'h0C, 8'h38, 8'h48};
  localparam logic [7:0] A_ALL [13] = '{8'h00, 8'h30, 8'h40, 8'h04, 8'h34, 8'h44,
                                        8'h0C, 8'h38, 8'h48, 8'h08, 8'h4C, 8'h80, 8'hFC};

  logic clk = 0, rst_n = 0, cfg_wr = 0, reg_wr = 0;
  logic [31:0] cfg_wdata = 0, reg_wdata = 0, cfg_rdata, reg_rdata;
  logic [7:0] reg_addr = 0;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  int vectors = 0, errors = 0;
  bit done = 0;

  logic m_en = 0;
  logic [95:0] m_use = '0, m_dir = '1, m_lvl = '0;

  always #4 clk = ~clk;

  gpio_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [95:0] m_deff();
    return (m_dir | IN_ONLY) & ~OUT_ONLY;
  endfunction

  function automatic logic [31:0] mread(input logic [7:0] a);
    logic [95:0] u, d, l;
    u = m_use & ~USE_ZERO & VALID;
    d = m_deff() & VALID;
    l = ((m_deff() & 96'(pin_in)) | (~m_deff() & m_lvl)) & VALID;
    if (!m_en || a >= WIN) return 32'd0;
    for (int b = 0; b < 3; b++) begin
      if (a == A_USE[b]) return u[b*32 +: 32];
      if (a == A_DIR[b]) return d[b*32 +: 32];
      if (a == A_LVL[b]) return l[b*32 +: 32];
    end
    return 32'd0;
  endfunction

  function automatic logic [95:0] m_oe();
    return m_en ? (~m_deff() & VALID) : 96'd0;
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    if (m_en && a < WIN)
      for (int b = 0; b < 3; b++) begin
        if (a == A_USE[b]) m_use[b*32 +: 32] = d;
        if (a == A_DIR[b]) m_dir[b*32 +: 32] = d;
        if (a == A_LVL[b]) m_lvl[b*32 +: 32] = d;
      end
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic cfg(input logic [31:0] d);
    @(negedge clk); cfg_wdata = d; cfg_wr = 1;
    @(posedge clk); m_en = d[4];
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, 96'(reg_rdata), 96'(mread(a)));
  endtask

  task automatic pins(input string tag);
    #1;
    chk({tag, " oe"}, 96'(pin_oe), m_oe());
    chk({tag, " out"}, 96'(pin_out), m_lvl & VALID);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    @(negedge clk);
    chk("R9 cfg reset", 96'(cfg_rdata), 96'd0);
    pins("R9 reset");
    rd("R8 read while disabled", 8'h04);
    // R8: writes ignored while disabled
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    cfg(32'h0000_00FF);
    chk("R8 cfg readback", 96'(cfg_rdata), 96'h10);
    pins("R8 write ignored while disabled");
    chk("R8 latch untouched", 96'(pin_out), 96'd0);
    // R9 and R2: reset direction read back; only output-only pins driven
    for (int b = 0; b < 3; b++) rd("R9 dir reset", A_DIR[b]);
    chk("R2 oe only fixed outputs", 96'(pin_oe), OUT_ONLY & VALID);
    // R3: input-only bit 5 ignores a clear
    wr(8'h04, 32'h0);
    rd("R3 fixed dir readback", 8'h04);
    chk("R3 bit5 stays input", 96'(reg_rdata[5]), 96'd1);
    pins("R3 in-only undriven");
    // R4: masked use bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd("R4 use mask", 8'h00);
    chk("R4 use value", 96'(reg_rdata), 96'hFFEC_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd("R4 use mask bank1", 8'h30);
    // R6: two-stage synchronizer
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[0] = 1'b1; reg_addr = 8'h0C;
    @(negedge clk); #1;
    chk("R6 not yet visible after one edge", 96'(reg_rdata[0]), 96'd0);
    @(negedge clk); #1;
    chk("R6 visible after two edges", 96'(reg_rdata[0]), 96'd1);
    // R5: latch written under input pins, read mux by direction
    wr(8'h0C, 32'hA5A5_A5A5);
    rd("R5 level reads inputs", 8'h0C);
    pins("R5 latch on pin_out");
    wr(8'h04, 32'h0);
    rd("R5 level reads latch", 8'h0C);
    // R1: pin 50 is bank1 bit18
    wr(8'h34, ~(32'd1 << 18));
    #1 chk("R1 pin50 driven", 96'(pin_oe[50]), 96'd1);
    pins("R1 bank1");
    // R7: window, holes and pins beyond NPINS
    wr(8'h44, 32'h0);
    wr(8'h48, 32'hFFFF_FFFF);
    rd("R7 bank2 level", 8'h48);
    chk("R7 bits beyond NPINS", 96'(reg_rdata[31:12]), 96'd0);
    rd("R7 hole 0x08", 8'h08);
    rd("R7 hole 0x4C", 8'h4C);
    rd("R7 beyond window 0x80", 8'h80);
    chk("R7 0x80 zero", 96'(reg_rdata), 96'd0);
    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom_range(0, 9));
      a = A_ALL[$urandom_range(0, 12)];
      if (op < 4) begin
        wr(a, $urandom());
        pins("R2 random pins");
      end else if (op < 8) begin
        rd("R1 random read", a);
      end else if (op == 8) begin
        @(negedge clk);
        pin_in = NPINS'({$urandom(), $urandom(), $urandom()});
        repeat (3) @(negedge clk);
        rd("R5 random level", A_LVL[$urandom_range(0, 2)]);
      end else begin
        cfg(($urandom_range(0, 3) != 0) ? 32'h10 : 32'h0);
        pins("R8 random enable");
      end
    end
    // R8: disable again
    cfg(32'h0);
    pins("R8 disabled oe");
    rd("R8 disabled read", 8'h0C);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule